// File: doc/BRIEF.md
# Multiplexed Waveform Playback Sequencer

This block replays a pre-loaded waveform one frame at a time from an external show-ahead FIFO. Each frame holds every analog channel value and one digital word in a fixed multiplexed order. On each sample tick during playback the block takes exactly one frame from the FIFO. It then drives all analog lanes and the digital word from registers that change together.

A commit strobe carries a control word. The word can load a static DC frame onto the outputs. It can also arm playback, which begins at once or waits for a chosen edge on the trigger line. A further bit selects a single pass of a programmed number of frames instead of endless playback. While playback is active, a level interrupt asks the host to refill the FIFO whenever the fill level is at or below a threshold. A sticky flag records any tick that found the FIFO empty.

Top module: `wave_replay_seq`

## Requirements
- R1: After reset all analog and digital outputs are zero, `busy`, `done`, `overrun` and `irq` are low, and `fifo_pop` stays low even when `tick` is high.
- R2: A commit whose control word has bit 0 (value 0x01) set copies `dc_frame` onto the outputs at the commit edge, whatever the other bits are.
- R3: With bit 1 (value 0x02) committed and `trig_mode` low, playback starts at the commit edge. From then on, each `tick` cycle with `fifo_empty` low raises `fifo_pop` in that same cycle and loads the presented frame into the outputs at that edge. A commit cycle never pops.
- R4: Frame layout: analog channel k occupies frame bits [16k+15:16k] (k = 0..31) and appears on `ao_out` at the same bit positions. The digital word occupies frame bits [575:512] and appears on `do_out`. All lanes update on the same edge.
- R5: With `trig_mode` high, an arm commit waits with `busy` high and ignores ticks until the selected edge of `trig_in`: rising when `trig_rise` is 1, falling when it is 0. The opposite edge is ignored. A tick in the edge cycle itself does not pop.
- R6: With bit 5 (value 0x20) also set, playback stops after `frame_len` frames (a length of 0 acts as 1). `done` then goes high, `busy` goes low, the last frame stays on the outputs, and later ticks do not pop. A new arm commit clears `done`.
- R7: Without bit 5, playback never stops on a frame count and pops on every tick with data present.
- R8: A tick during playback with `fifo_empty` high does not pop, keeps the outputs unchanged, and sets `overrun` at that edge.
- R9: `overrun` stays set until a cycle with `ovr_clr` high. If a starved tick and `ovr_clr` fall in the same cycle, the flag is set.
- R10: `irq` is registered: it is high in the cycle after one in which the block was busy and `fifo_level <= tide_level`, and low otherwise.
- R11: A commit with bit 1 clear stops any armed or running playback (`busy` low), after which ticks do not pop.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| cmt_valid | input | 1 | Control word commit strobe |
| cmt_word | input | 8 | Control word: bit0 DC load, bit1 arm, bit5 single pass |
| trig_mode | input | 1 | 1 = armed playback waits for trigger edge |
| trig_rise | input | 1 | Trigger edge select, 1 rising, 0 falling |
| trig_in | input | 1 | Trigger line |
| tick | input | 1 | Sample clock tick, one cycle wide |
| frame_len | input | 16 | Frames played in single-pass mode |
| tide_level | input | 12 | Low-tide threshold |
| fifo_level | input | 12 | FIFO fill level |
| fifo_empty | input | 1 | FIFO empty |
| fifo_data | input | 576 | Frame at FIFO head |
| dc_frame | input | 576 | Static frame applied by DC load |
| ovr_clr | input | 1 | Clears the overrun flag |
| fifo_pop | output | 1 | Takes the head frame this cycle |
| ao_out | output | 512 | Analog lanes, 32 x 16 bits |
| do_out | output | 64 | Digital output word |
| busy | output | 1 | Armed or playing |
| done | output | 1 | Single pass completed |
| overrun | output | 1 | Sticky starvation flag |
| irq | output | 1 | Low-tide refill request |

## Verification
Two pairs of functions can meet in one cycle. The first pair is a starved tick and a software clear of the overrun flag. The bench drives both together with an empty FIFO and expects the flag to stay set. The second pair is a trigger edge and a sample tick: the bench raises the tick in the edge cycle and expects no pop until the next tick. Single-pass runs are swept over lengths 0 to 5 in immediate mode and in both edge polarities, each time after a deliberate wrong-polarity edge. Every frame is compared lane by lane with a pattern computed from its index.

// File: rtl/wave_replay_pkg.sv
package wave_replay_pkg;

  typedef enum logic [1:0] {
    ST_IDLE  = 2'd0,
    ST_ARMED = 2'd1,
    ST_PLAY  = 2'd2
  } seq_state_t;

  // Control word bit positions
  localparam int unsigned CW_DC   = 0;
  localparam int unsigned CW_ARM  = 1;
  localparam int unsigned CW_ONCE = 5;

  // True when the frame about to be taken completes a single pass.
  function automatic logic pass_complete(input int unsigned taken,
                                         input int unsigned length);
    return (taken + 1) >= length;
  endfunction

  // True when the fill level has reached the refill threshold.
  function automatic logic at_low_tide(input int unsigned level,
                                       input int unsigned thresh);
    return level <= thresh;
  endfunction

endpackage

// File: rtl/wave_trig_detect.sv
module wave_trig_detect (
  input  logic clk,
  input  logic rst_n,
  input  logic trig_in,
  input  logic rise_sel,
  output logic edge_hit
);
  logic trig_q;

  always_ff @(posedge clk) begin
    if (!rst_n) trig_q <= 1'b0;
    else        trig_q <= trig_in;
  end

  assign edge_hit = rise_sel ? (trig_in & ~trig_q) : (~trig_in & trig_q);
endmodule

// File: rtl/wave_seq_ctrl.sv
module wave_seq_ctrl
  import wave_replay_pkg::*;
#(
  parameter int unsigned LEN_W = 16,
  parameter int unsigned CW_W  = 8
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             cmt_valid,
  input  logic [CW_W-1:0]  cmt_word,
  input  logic             trig_mode,
  input  logic             edge_hit,
  input  logic             tick,
  input  logic             fifo_empty,
  input  logic [LEN_W-1:0] frame_len,
  output logic             pop,
  output logic             starve,
  output logic             busy,
  output logic             done
);
  seq_state_t       state_q;
  logic             once_q;
  logic [LEN_W-1:0] taken_q;
  logic             playing;

  assign playing = (state_q == ST_PLAY) && !cmt_valid;
  assign pop     = playing && tick && !fifo_empty;
  assign starve  = playing && tick && fifo_empty;
  assign busy    = (state_q != ST_IDLE);

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      state_q <= ST_IDLE;
      once_q  <= 1'b0;
      taken_q <= '0;
      done    <= 1'b0;
    end else if (cmt_valid) begin
      if (cmt_word[CW_ARM]) begin
        state_q <= trig_mode ? ST_ARMED : ST_PLAY;
        once_q  <= cmt_word[CW_ONCE];
        taken_q <= '0;
        done    <= 1'b0;
      end else begin
        state_q <= ST_IDLE;
      end
    end else begin
      case (state_q)
        ST_ARMED: if (edge_hit) state_q <= ST_PLAY;
        ST_PLAY: if (pop) begin
          taken_q <= taken_q + 1'b1;
          if (once_q && pass_complete(32'(taken_q), 32'(frame_len))) begin
            state_q <= ST_IDLE;
            done    <= 1'b1;
          end
        end
        default: ;
      endcase
    end
  end

  // R5: a waiting sequencer never takes a frame
  p_armed_no_pop_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (state_q == ST_ARMED) |-> !pop);
endmodule

// File: rtl/wave_frame_hold.sv
module wave_frame_hold #(
  parameter int unsigned N_AO = 32,
  parameter int unsigned AO_W = 16,
  parameter int unsigned DO_W = 64,
  localparam int unsigned AO_BITS = N_AO * AO_W,
  localparam int unsigned FRAME_W = AO_BITS + DO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               load_dc,
  input  logic               pop,
  input  logic [FRAME_W-1:0] dc_frame,
  input  logic [FRAME_W-1:0] fifo_data,
  output logic [AO_BITS-1:0] ao_out,
  output logic [DO_W-1:0]    do_out
);
  logic [FRAME_W-1:0] src;
  logic               load;

  assign load = load_dc | pop;
  assign src  = load_dc ? dc_frame : fifo_data;

  for (genvar k = 0; k < N_AO; k++) begin : g_lane
    always_ff @(posedge clk) begin
      if (!rst_n)    ao_out[k*AO_W +: AO_W] <= '0;
      else if (load) ao_out[k*AO_W +: AO_W] <= src[k*AO_W +: AO_W];
    end
  end

  always_ff @(posedge clk) begin
    if (!rst_n)    do_out <= '0;
    else if (load) do_out <= src[AO_BITS +: DO_W];
  end

  // R4: a popped frame lands on every lane at once
  p_pop_loads_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (pop && !load_dc) |=> (ao_out == $past(fifo_data[AO_BITS-1:0]))
                         && (do_out == $past(fifo_data[AO_BITS +: DO_W])));
endmodule

// File: rtl/wave_status_flags.sv
module wave_status_flags
  import wave_replay_pkg::*;
#(
  parameter int unsigned LVL_W = 12
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             starve,
  input  logic             ovr_clr,
  input  logic             busy,
  input  logic [LVL_W-1:0] fifo_level,
  input  logic [LVL_W-1:0] tide_level,
  output logic             overrun,
  output logic             irq
);
  always_ff @(posedge clk) begin
    if (!rst_n) begin
      overrun <= 1'b0;
      irq     <= 1'b0;
    end else begin
      if (starve)       overrun <= 1'b1;
      else if (ovr_clr) overrun <= 1'b0;
      irq <= busy && at_low_tide(32'(fifo_level), 32'(tide_level));
    end
  end

  // R9: the flag only falls on a clear request
  p_ovr_sticky_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (overrun && !ovr_clr) |=> overrun);
  // R8: a starved tick always leaves the flag set
  p_starve_sets_r8: assert property (@(posedge clk) disable iff (!rst_n)
    starve |=> overrun);
endmodule

// File: rtl/wave_replay_seq.sv
module wave_replay_seq
  import wave_replay_pkg::*;
#(
  parameter int unsigned N_AO  = 32,
  parameter int unsigned AO_W  = 16,
  parameter int unsigned DO_W  = 64,
  parameter int unsigned LEN_W = 16,
  parameter int unsigned LVL_W = 12,
  localparam int unsigned AO_BITS = N_AO * AO_W,
  localparam int unsigned FRAME_W = AO_BITS + DO_W
) (
  input  logic               clk,
  input  logic               rst_n,
  input  logic               cmt_valid,
  input  logic [7:0]         cmt_word,
  input  logic               trig_mode,
  input  logic               trig_rise,
  input  logic               trig_in,
  input  logic               tick,
  input  logic [LEN_W-1:0]   frame_len,
  input  logic [LVL_W-1:0]   tide_level,
  input  logic [LVL_W-1:0]   fifo_level,
  input  logic               fifo_empty,
  input  logic [FRAME_W-1:0] fifo_data,
  input  logic [FRAME_W-1:0] dc_frame,
  input  logic               ovr_clr,
  output logic               fifo_pop,
  output logic [AO_BITS-1:0] ao_out,
  output logic [DO_W-1:0]    do_out,
  output logic               busy,
  output logic               done,
  output logic               overrun,
  output logic               irq
);
  logic edge_hit;
  logic starve;
  logic load_dc;

  assign load_dc = cmt_valid && cmt_word[CW_DC];

  wave_trig_detect u_trig (
    .clk(clk), .rst_n(rst_n), .trig_in(trig_in), .rise_sel(trig_rise),
    .edge_hit(edge_hit)
  );

  wave_seq_ctrl #(.LEN_W(LEN_W), .CW_W(8)) u_ctrl (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_word(cmt_word),
    .trig_mode(trig_mode), .edge_hit(edge_hit), .tick(tick),
    .fifo_empty(fifo_empty), .frame_len(frame_len), .pop(fifo_pop),
    .starve(starve), .busy(busy), .done(done)
  );

  wave_frame_hold #(.N_AO(N_AO), .AO_W(AO_W), .DO_W(DO_W)) u_hold (
    .clk(clk), .rst_n(rst_n), .load_dc(load_dc), .pop(fifo_pop),
    .dc_frame(dc_frame), .fifo_data(fifo_data), .ao_out(ao_out),
    .do_out(do_out)
  );

  wave_status_flags #(.LVL_W(LVL_W)) u_flags (
    .clk(clk), .rst_n(rst_n), .starve(starve), .ovr_clr(ovr_clr),
    .busy(busy), .fifo_level(fifo_level), .tide_level(tide_level),
    .overrun(overrun), .irq(irq)
  );

  // R8: outputs move only on a pop or a DC load
  p_hold_when_quiet_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (!fifo_pop && !load_dc) |=> ($stable(ao_out) && $stable(do_out)));
  // R6: a finished single pass takes no more frames
  p_done_no_pop_r6: assert property (@(posedge clk) disable iff (!rst_n)
    done |-> !fifo_pop);
  // R8: an empty FIFO is never popped
  p_no_pop_empty_r8: assert property (@(posedge clk) disable iff (!rst_n)
    fifo_empty |-> !fifo_pop);
endmodule

// File: tb/wave_replay_seq_tb.sv
module wave_replay_seq_tb;
  localparam int CLK_PERIOD = 10;
  localparam int N_AO = 32;
  localparam int AO_W = 16;
  localparam int DO_W = 64;
  localparam int AO_BITS = N_AO * AO_W;
  localparam int FRAME_W = AO_BITS + DO_W;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic cmt_valid = 1'b0;
  logic [7:0] cmt_word = '0;
  logic trig_mode = 1'b0, trig_rise = 1'b1, trig_in = 1'b0, tick = 1'b0;
  logic [15:0] frame_len = '0;
  logic [11:0] tide_level = '0, fifo_level = 12'd100;
  logic fifo_empty = 1'b0, ovr_clr = 1'b0;
  logic [FRAME_W-1:0] fifo_data, dc_frame = '0;
  logic fifo_pop, busy, done, overrun, irq;
  logic [AO_BITS-1:0] ao_out;
  logic [DO_W-1:0] do_out;

  int checks = 0, errors = 0, rd_idx = 0;
  bit finished = 0;

  always #(CLK_PERIOD/2) clk = ~clk;

  wave_replay_seq u_dut (
    .clk(clk), .rst_n(rst_n), .cmt_valid(cmt_valid), .cmt_word(cmt_word),
    .trig_mode(trig_mode), .trig_rise(trig_rise), .trig_in(trig_in),
    .tick(tick), .frame_len(frame_len), .tide_level(tide_level),
    .fifo_level(fifo_level), .fifo_empty(fifo_empty), .fifo_data(fifo_data),
    .dc_frame(dc_frame), .ovr_clr(ovr_clr), .fifo_pop(fifo_pop),
    .ao_out(ao_out), .do_out(do_out), .busy(busy), .done(done),
    .overrun(overrun), .irq(irq)
  );

  function automatic logic [FRAME_W-1:0] mk_frame(input int i);
    logic [FRAME_W-1:0] f;
    for (int k = 0; k < N_AO; k++) f[k*AO_W +: AO_W] = 16'(i*613 + k*97 + 3);
    f[AO_BITS +: DO_W] = {32'(i*7 + 1), ~32'(i)};
    return f;
  endfunction

  always_comb fifo_data = mk_frame(rd_idx);
  always @(posedge clk) if (rst_n && fifo_pop) rd_idx <= rd_idx + 1;

  task automatic chk(input bit ok, input string req, input string what,
                     input logic [FRAME_W-1:0] act, input logic [FRAME_W-1:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s %s: actual %0h expected %0h", req, what, act, exp);
    end
  endtask

  task automatic chk_frame(input logic [FRAME_W-1:0] exp, input string req);
    logic [FRAME_W-1:0] act;
    act = {do_out, ao_out};
    chk(act == exp, req, "outputs", act, exp);
  endtask

  task automatic step();
    @(negedge clk);
  endtask

  task automatic commit(input logic [7:0] w);
    cmt_valid = 1'b1; cmt_word = w;
    step();
    cmt_valid = 1'b0; cmt_word = '0;
  endtask

  // one tick cycle; returns the pop seen before the edge
  task automatic tick_cyc(output logic p);
    tick = 1'b1;
    #1 p = fifo_pop;
    step();
    tick = 1'b0;
  endtask

  task automatic run_oneshot(input int len, input bit trg, input bit rise);
    int start, n;
    logic p;
    frame_len = 16'(len); trig_mode = trg; trig_rise = rise;
    if (trg) begin trig_in = rise; step(); end
    start = rd_idx;
    commit(8'h22);
    chk(done == 1'b0 && busy == 1'b1, "R6", "rearm clears done", {done, busy}, 2'b01);
    if (trg) begin
      trig_in = ~trig_in;  // wrong polarity
      tick_cyc(p);
      chk(p == 1'b0, "R5", "wrong edge pop", p, 0);
      trig_in = ~trig_in;  // selected polarity, tick in same cycle
      tick_cyc(p);
      chk(p == 1'b0, "R5", "edge-cycle pop", p, 0);
      chk(busy == 1'b1, "R5", "busy after edge", busy, 1);
    end
    n = (len == 0) ? 1 : len;
    for (int j = 0; j < n + 2; j++) begin
      tick_cyc(p);
      chk(p == (j < n), "R6", "pop per tick", p, (j < n));
      if (j < n) chk_frame(mk_frame(start + j), "R4");
    end
    chk(done == 1'b1 && busy == 1'b0, "R6", "done/busy", {done, busy}, 2'b10);
    chk_frame(mk_frame(start + n - 1), "R6");
  endtask

  initial begin : watchdog
    repeat (20000) @(posedge clk);
    if (!finished) begin
      checks++; errors++;
      $display("FAIL watchdog: actual timeout expected completion");
      $display("Simulation finished: %0d checks, %0d errors", checks, errors);
      $finish;
    end
  end

  initial begin : main
    logic p;
    int start;
    step();
    tick = 1'b1;
    step(); step();
    #1 chk(fifo_pop == 1'b0, "R1", "pop in reset", fifo_pop, 0);
    step();
    rst_n = 1'b1;
    #1 chk(fifo_pop == 1'b0, "R1", "pop idle", fifo_pop, 0);
    step();
    tick = 1'b0;
    chk({do_out, ao_out} == '0, "R1", "outputs zero", {do_out, ao_out}, '0);
    chk({busy, done, overrun, irq} == 4'b0, "R1", "status", {busy, done, overrun, irq}, 0);

    // R2: DC load
    dc_frame = ~mk_frame(999);
    commit(8'h01);
    chk_frame(~mk_frame(999), "R2");
    chk(busy == 1'b0, "R2", "DC only stays idle", busy, 0);

    // single-pass sweep
    for (int len = 0; len <= 5; len++) begin
      run_oneshot(len, 1'b0, 1'b0);
      run_oneshot(len, 1'b1, 1'b1);
      run_oneshot(len, 1'b1, 1'b0);
    end

    // R3 / R7: continuous playback
    trig_mode = 1'b0; frame_len = 16'd2;
    start = rd_idx;
    commit(8'h02);
    for (int j = 0; j < 6; j++) begin
      tick_cyc(p);
      chk(p == 1'b1, "R7", "continuous pop", p, 1);
      chk_frame(mk_frame(start + j), "R3");
    end
    chk(busy == 1'b1 && done == 1'b0, "R7", "still running", {busy, done}, 2'b10);

    // R8 / R9: starvation
    fifo_empty = 1'b1;
    tick_cyc(p);
    chk(p == 1'b0, "R8", "pop while empty", p, 0);
    chk(overrun == 1'b1, "R8", "overrun set", overrun, 1);
    chk_frame(mk_frame(start + 5), "R8");
    fifo_empty = 1'b0;
    tick_cyc(p);
    chk(p == 1'b1 && overrun == 1'b1, "R9", "sticky", {p, overrun}, 2'b11);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;
    chk(overrun == 1'b0, "R9", "clear", overrun, 0);
    ovr_clr = 1'b1; fifo_empty = 1'b1;
    tick_cyc(p);
    ovr_clr = 1'b0; fifo_empty = 1'b0;
    chk(overrun == 1'b1, "R9", "set wins over clear", overrun, 1);
    ovr_clr = 1'b1; step(); ovr_clr = 1'b0;

    // R10: low-tide interrupt while busy
    tide_level = 12'd10;
    fifo_level = 12'd10; step();
    chk(irq == 1'b1, "R10", "level at threshold", irq, 1);
    fifo_level = 12'd11; step();
    chk(irq == 1'b0, "R10", "level above threshold", irq, 0);
    fifo_level = 12'd0; step();
    chk(irq == 1'b1, "R10", "level below threshold", irq, 1);

    // R11: stop
    commit(8'h00);
    step();
    chk(busy == 1'b0 && irq == 1'b0, "R11", "stopped, irq low", {busy, irq}, 0);
    tick_cyc(p);
    chk(p == 1'b0, "R11", "tick after stop", p, 0);
    fifo_level = 12'd100;

    // R2 with arm in triggered mode
    trig_mode = 1'b1; trig_rise = 1'b1; trig_in = 1'b0; step();
    dc_frame = mk_frame(4242);
    commit(8'h03);
    chk_frame(mk_frame(4242), "R2");
    chk(busy == 1'b1, "R5", "armed after DC+arm", busy, 1);
    start = rd_idx;
    trig_in = 1'b1; step();
    tick_cyc(p);
    chk(p == 1'b1, "R5", "pop after edge", p, 1);
    chk_frame(mk_frame(start), "R5");
    commit(8'h00);

    finished = 1;
    $display("Simulation finished: %0d checks, %0d errors", checks, errors);
    $finish;
  end
endmodule